// File: doc/BRIEF.md
# Serial Converter Sample Sequencer

This block is the host side of a link to a 12-bit serial sampling converter. It owns the conversion-start line and the serial clock. For each sample it shifts a configuration word out to the converter and gathers the converter's result word in. A pulse on the start input begins one sample. Each finished transfer raises a one-cycle valid strobe that carries the result together with a tag.

Three read modes set where the transfer sits relative to the conversion pulse:
- **After-conversion:** the whole transfer runs during acquisition.
- **During-conversion:** the whole transfer runs after a short conversion pulse.
- **Spanning:** the transfer is split across the pulse.

The acquisition time, the conversion time and the serial clock half-period are run-time counts in clock cycles. The serial clock is never active while the conversion line is high.

The converter always returns the result of the conversion before the one being started. For that reason each result is tagged with the number of conversions issued before the current sample's own pulse.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `cnv_o` is high, `sclk_o` is low, `busy_o` is low and `res_valid_o` is low.
- R2: `sclk_o` is low in every cycle where `cnv_o` is high and in every cycle where `busy_o` is low.
- R3: Mode code 00 (after-conversion) puts all 12 serial clock rising edges before `cnv_o` rises. Within the sample, `cnv_o` stays low for exactly max(A, 24·H+1) cycles, where A is `acq_cyc_i` and H is the effective half-period. Code 11 behaves as code 00.
- R4: In after-conversion mode, `cnv_o` stays high for exactly `conv_cyc_i` cycles before the sample ends. It remains high afterwards.
- R5: Mode code 01 (during-conversion) holds `cnv_o` low for exactly `acq_cyc_i` cycles and then high for 2 cycles. All 12 serial clock rising edges follow, with `cnv_o` low.
- R6: Mode code 10 (spanning) gives 6 rising edges before the pulse and 6 after it. `cnv_o` stays low for exactly max(A, 12·H+1) cycles before the 2-cycle pulse.
- R7: A new sample (the rise of `busy_o`) begins no earlier than `conv_cyc_i` cycles after the last rise of `cnv_o`.
- R8: `sdi_o` carries `cfg_i` MSB first. Each bit is valid at a rising edge of `sclk_o`.
- R9: `sdo_i` is captured in the cycle `sclk_o` is driven low, i.e. at the end of each high phase, MSB first. `res_valid_o` is a one-cycle pulse with the 12-bit word on `res_data_o`.
- R10: `res_tag_o` equals the number of conversion pulses issued before the sample's own pulse. The n-th sample after reset, counting from 0, carries tag n.
- R11: The mode is taken only when a start is accepted from idle. Changes on `mode_i`, and start pulses, during a busy sample have no effect.
- R12: Each high phase of `sclk_o` lasts exactly H cycles, where H is `sclk_half_i` and a value of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin one sample when idle |
| mode_i | input | 2 | Read mode: 00 after, 01 during, 10 spanning, 11 as 00 |
| cfg_i | input | 12 | Configuration word shifted out |
| acq_cyc_i | input | 16 | Minimum acquisition time in cycles |
| conv_cyc_i | input | 16 | Conversion time in cycles |
| sclk_half_i | input | 8 | Serial clock half-period in cycles |
| cnv_o | output | 1 | Conversion-start line to the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| sdi_o | output | 1 | Serial data to the converter |
| sdo_i | input | 1 | Serial data from the converter |
| busy_o | output | 1 | A sample is in progress |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_data_o | output | 12 | Result word |
| res_tag_o | output | 8 | Count of conversions before this sample's pulse |

## Verification
In after-conversion and spanning modes, the acquisition timer can expire in the same cycle that the transfer reaches its required bit count. The pulse must then start on the very next edge, with no extra wait and no serial clock overlap. The bench provokes this coincidence by setting the acquisition count to exactly the transfer length plus one (25 cycles at H=1 for after-conversion, 13 for spanning). It judges the result by the exact low time of the conversion line and the number of serial edges before the pulse. Neighbouring samples, where the timer dominates or the transfer dominates, show that the larger of the two always decides.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        MODE_AFTER  = 2'b00,
        MODE_DURING = 2'b01,
        MODE_SPAN   = 2'b10
    } rd_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACQ,
        ST_HOLD,
        ST_TAIL
    } seq_state_e;

    typedef struct packed {
        rd_mode_e    mode;
        logic [7:0]  lead;   // bits to move before the conversion pulse
    } smp_ctx_t;

    function automatic rd_mode_e decode_mode(logic [1:0] code);
        case (code)
            2'b01:   return MODE_DURING;
            2'b10:   return MODE_SPAN;
            default: return MODE_AFTER;
        endcase
    endfunction

    function automatic logic [7:0] lead_for(rd_mode_e m, int unsigned dw, int unsigned sp);
        case (m)
            MODE_DURING: return 8'd0;
            MODE_SPAN:   return 8'(sp);
            default:     return 8'(dw);
        endcase
    endfunction

endpackage

// File: rtl/adc_seq_tmr.sv
module adc_seq_tmr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o
);
    // Saturating up-counter; clear has priority.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_o <= '1;
        end else if (clr_i) begin
            cnt_o <= '0;
        end else if (cnt_o != '1) begin
            cnt_o <= cnt_o + W'(1);
        end
    end
endmodule

// File: rtl/adc_seq_shift.sv
module adc_seq_shift #(
    parameter int DATA_W = 12,
    parameter int DIV_W  = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         load_i,
    input  logic                         run_i,
    input  logic [DATA_W-1:0]            tx_word_i,
    input  logic [DIV_W-1:0]             half_i,
    input  logic                         sdo_i,
    output logic                         sclk_o,
    output logic                         sdi_o,
    output logic                         active_o,
    output logic                         done_o,
    output logic [$clog2(DATA_W+1)-1:0]  bits_o,
    output logic [DATA_W-1:0]            rx_o
);
    localparam int BIT_W = $clog2(DATA_W + 1);

    logic [DIV_W-1:0]  ph_q;
    logic [DATA_W-1:0] tx_q;
    logic [DATA_W-1:0] rx_q;
    logic [BIT_W-1:0]  bits_q;
    logic              act_q;
    logic              sclk_q;
    logic              done_q;
    logic              edge_due;

    // Half-period elapsed; a zero setting behaves as one cycle.
    assign edge_due = ({1'b0, ph_q} + (DIV_W+1)'(1)) >= {1'b0, half_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= '0;
            tx_q   <= '0;
            rx_q   <= '0;
            bits_q <= '0;
            act_q  <= 1'b0;
            sclk_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load_i) begin
                tx_q   <= tx_word_i;
                bits_q <= '0;
                ph_q   <= '0;
                sclk_q <= 1'b0;
                act_q  <= 1'b1;
            end else if (run_i && act_q) begin
                if (edge_due) begin
                    ph_q <= '0;
                    if (!sclk_q) begin
                        sclk_q <= 1'b1;
                    end else begin
                        sclk_q <= 1'b0;
                        rx_q   <= {rx_q[DATA_W-2:0], sdo_i};
                        tx_q   <= {tx_q[DATA_W-2:0], 1'b0};
                        bits_q <= bits_q + BIT_W'(1);
                        if (bits_q == BIT_W'(DATA_W - 1)) begin
                            act_q  <= 1'b0;
                            done_q <= 1'b1;
                        end
                    end
                end else begin
                    ph_q <= ph_q + DIV_W'(1);
                end
            end
        end
    end

    assign sclk_o   = sclk_q;
    assign sdi_o    = tx_q[DATA_W-1];
    assign active_o = act_q;
    assign done_o   = done_q;
    assign bits_o   = bits_q;
    assign rx_o     = rx_q;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int DATA_W     = 12,
    parameter int CNT_W      = 16,
    parameter int DIV_W      = 8,
    parameter int TAG_W      = 8,
    parameter int SPLIT_BITS = 6,
    parameter int PULSE_CYC  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [1:0]        mode_i,
    input  logic [DATA_W-1:0] cfg_i,
    input  logic [CNT_W-1:0]  acq_cyc_i,
    input  logic [CNT_W-1:0]  conv_cyc_i,
    input  logic [DIV_W-1:0]  sclk_half_i,
    output logic              cnv_o,
    output logic              sclk_o,
    output logic              sdi_o,
    input  logic              sdo_i,
    output logic              busy_o,
    output logic              res_valid_o,
    output logic [DATA_W-1:0] res_data_o,
    output logic [TAG_W-1:0]  res_tag_o
);
    localparam int BIT_W = $clog2(DATA_W + 1);

    seq_state_e        state_q, state_d;
    smp_ctx_t          ctx_q, ctx_d;
    logic              cnv_q, cnv_d;
    logic [TAG_W-1:0]  num_q, num_d;
    logic [TAG_W-1:0]  tag_q, tag_d;

    logic              ph_clr, cv_clr, x_load, x_run;
    logic [CNT_W-1:0]  ph_cnt, cv_cnt;
    logic              x_act, x_done;
    logic [BIT_W-1:0]  x_bits;
    logic [DATA_W-1:0] x_rx;
    logic              acq_met, conv_met, pulse_met, lead_met;
    rd_mode_e          cur_mode;

    adc_seq_tmr #(.W(CNT_W)) u_ph_tmr (
        .clk(clk), .rst(rst), .clr_i(ph_clr), .cnt_o(ph_cnt)
    );

    adc_seq_tmr #(.W(CNT_W)) u_cv_tmr (
        .clk(clk), .rst(rst), .clr_i(cv_clr), .cnt_o(cv_cnt)
    );

    adc_seq_shift #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_shift (
        .clk(clk), .rst(rst),
        .load_i(x_load), .run_i(x_run),
        .tx_word_i(cfg_i), .half_i(sclk_half_i), .sdo_i(sdo_i),
        .sclk_o(sclk_o), .sdi_o(sdi_o),
        .active_o(x_act), .done_o(x_done),
        .bits_o(x_bits), .rx_o(x_rx)
    );

    assign acq_met   = ({1'b0, ph_cnt} + (CNT_W+1)'(1)) >= {1'b0, acq_cyc_i};
    assign conv_met  = ({1'b0, cv_cnt} + (CNT_W+1)'(1)) >= {1'b0, conv_cyc_i};
    assign pulse_met = ph_cnt >= CNT_W'(PULSE_CYC - 1);
    assign lead_met  = int'(x_bits) >= int'(ctx_q.lead);
    assign cur_mode  = ctx_q.mode;

    always_comb begin
        state_d = state_q;
        ctx_d   = ctx_q;
        cnv_d   = cnv_q;
        num_d   = num_q;
        tag_d   = tag_q;
        ph_clr  = 1'b0;
        cv_clr  = 1'b0;
        x_load  = 1'b0;
        x_run   = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    ctx_d.mode = decode_mode(mode_i);
                    ctx_d.lead = lead_for(decode_mode(mode_i), DATA_W, SPLIT_BITS);
                    tag_d      = num_q;
                    x_load     = 1'b1;
                    ph_clr     = 1'b1;
                    cnv_d      = 1'b0;
                    state_d    = ST_ACQ;
                end
            end
            ST_ACQ: begin
                x_run = !lead_met;
                if (acq_met && lead_met) begin
                    cnv_d   = 1'b1;
                    cv_clr  = 1'b1;
                    ph_clr  = 1'b1;
                    num_d   = num_q + TAG_W'(1);
                    state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (ctx_q.mode == MODE_AFTER) begin
                    if (conv_met) state_d = ST_IDLE;
                end else if (pulse_met) begin
                    cnv_d   = 1'b0;
                    state_d = ST_TAIL;
                end
            end
            ST_TAIL: begin
                x_run = 1'b1;
                if (!x_act && conv_met) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ctx_q   <= '{mode: MODE_AFTER, lead: 8'd0};
            cnv_q   <= 1'b1;
            num_q   <= '0;
            tag_q   <= '0;
        end else begin
            state_q <= state_d;
            ctx_q   <= ctx_d;
            cnv_q   <= cnv_d;
            num_q   <= num_d;
            tag_q   <= tag_d;
        end
    end

    assign cnv_o       = cnv_q;
    assign busy_o      = (state_q != ST_IDLE);
    assign res_valid_o = x_done;
    assign res_data_o  = x_rx;
    assign res_tag_o   = tag_q;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int DATA_W     = 12,
    parameter int SPLIT_BITS = 6
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        cnv,
    input logic                        sclk,
    input logic                        busy,
    input logic                        res_valid,
    input logic [1:0]                  mode,
    input logic                        xfer_act,
    input logic [$clog2(DATA_W+1)-1:0] bits
);
    // R2
    cnv_sclk_low_chk: assert property (@(posedge clk) disable iff (rst)
        cnv |-> !sclk);

    // R2
    idle_sclk_low_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sclk);

    // R3
    after_xfer_first_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(cnv) && mode == 2'b00) |-> (!xfer_act && int'(bits) == DATA_W));

    // R5
    during_no_lead_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(cnv) && mode == 2'b01) |-> (bits == '0));

    // R6
    span_split_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(cnv) && mode == 2'b10) |-> (int'(bits) == SPLIT_BITS));

    // R9
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    // R11
    mode_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(mode));
endmodule

bind adc_seq_ctrl adc_seq_chk #(.DATA_W(DATA_W), .SPLIT_BITS(SPLIT_BITS)) u_chk (
    .clk(clk), .rst(rst), .cnv(cnv_o), .sclk(sclk_o), .busy(busy_o),
    .res_valid(res_valid_o), .mode(cur_mode), .xfer_act(x_act), .bits(x_bits)
);

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  mode_sel = 2'b00;
    logic [11:0] cfg = '0;
    logic [15:0] acq_cyc = 16'd4;
    logic [15:0] conv_cyc = 16'd4;
    logic [7:0]  half = 8'd1;
    logic        cnv, sclk, sdi, sdo, busy, res_valid;
    logic [11:0] res_data;
    logic [7:0]  res_tag;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    adc_seq_ctrl u0 (
        .clk(clk), .rst(rst), .start_i(start), .mode_i(mode_sel), .cfg_i(cfg),
        .acq_cyc_i(acq_cyc), .conv_cyc_i(conv_cyc), .sclk_half_i(half),
        .cnv_o(cnv), .sclk_o(sclk), .sdi_o(sdi), .sdo_i(sdo), .busy_o(busy),
        .res_valid_o(res_valid), .res_data_o(res_data), .res_tag_o(res_tag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Converter model: word loaded at an accepted start, shifted after each fall.
    logic [11:0] pending = '0;
    logic [11:0] sr = '0;
    logic        sclk_d = 1'b0;
    assign sdo = sr[11];

    always @(posedge clk) begin
        sclk_d <= sclk;
        if (start && !busy) sr <= pending;
        else if (sclk_d && !sclk) sr <= {sr[10:0], 1'b0};
    end

    // Scoreboard
    typedef struct {
        logic [11:0] data;
        int          tag;
    } exp_t;
    exp_t exp_q[$];
    int   n_samples = 0;

    always @(negedge clk) begin
        if (!rst && res_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 unexpected result", int'(res_data), -1);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(res_data == e.data, "R9 result word", int'(res_data), int'(e.data));
                chk(int'(res_tag) == e.tag, "R10 result tag", int'(res_tag), e.tag);
            end
        end
    end

    // Global timing monitor
    int   since_rise = 1000000;
    int   last_conv = 0;
    bit   cnv_p = 1'b1, busy_p = 1'b0;
    int   r2_viol = 0;

    always @(negedge clk) begin
        if (!rst) begin
            since_rise++;
            if (cnv && !cnv_p) begin
                since_rise = 0;
                last_conv  = int'(conv_cyc);
            end
            if (busy && !busy_p)
                chk(since_rise >= last_conv, "R7 acquisition spacing", since_rise, last_conv);
            if (sclk && (cnv || !busy)) r2_viol++;
            cnv_p  = cnv;
            busy_p = busy;
        end
    end

    // Driver: one sample, measured at the ports.
    task automatic run_sample(input logic [1:0] m, input logic [11:0] c, input logic [11:0] w,
                              input int acq, input int conv, input int h,
                              input int exp_kind, input int late);
        int low = 0, high = 0, pre = 0, post = 0, cyc = 0, hi_run = 0, hi_bad = 0;
        int heff, exp_low, exp_high, exp_pre;
        bit seen = 1'b0, sp = 1'b0;
        logic [11:0] sdi_word = '0;
        exp_t e;
        heff = (h == 0) ? 1 : h;
        while (busy) @(negedge clk);
        mode_sel = m; cfg = c; pending = w;
        acq_cyc = 16'(acq); conv_cyc = 16'(conv); half = 8'(h);
        e.data = w; e.tag = n_samples;
        exp_q.push_back(e);
        n_samples++;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy) begin
            if (late > 0 && cyc == late) begin mode_sel = 2'b00; start = 1'b1; end
            if (late > 0 && cyc == late + 1) start = 1'b0;
            if (cnv) begin high++; seen = 1'b1; end
            else if (!seen) low++;
            if (sclk && !sp) begin
                if (seen) post++; else pre++;
                sdi_word = {sdi_word[10:0], sdi};
            end
            if (sclk) hi_run++;
            else if (sp) begin
                if (hi_run != heff) hi_bad = hi_run;
                hi_run = 0;
            end
            sp = sclk;
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        // exp_kind: 0 after-conversion, 1 during, 2 spanning
        if (exp_kind == 0) begin
            exp_low  = (acq > 24 * heff + 1) ? acq : 24 * heff + 1;
            exp_high = conv; exp_pre = 12;
            chk(low == exp_low, "R3 low time", low, exp_low);
            chk(high == exp_high, "R4 high time", high, exp_high);
            chk(pre == exp_pre && post == 0, "R3 edges before pulse", pre, exp_pre);
        end else if (exp_kind == 1) begin
            chk(low == acq, "R5 low time", low, acq);
            chk(high == 2, "R5 pulse width", high, 2);
            chk(pre == 0 && post == 12, "R5 edges after pulse", post, 12);
        end else begin
            exp_low = (acq > 12 * heff + 1) ? acq : 12 * heff + 1;
            chk(low == exp_low, "R6 low time", low, exp_low);
            chk(high == 2, "R6 pulse width", high, 2);
            chk(pre == 6 && post == 6, "R6 split edges", pre * 100 + post, 606);
        end
        chk(sdi_word == c, "R8 config word", int'(sdi_word), int'(c));
        chk(hi_bad == 0, "R12 high phase", hi_bad, heff);
        if (late > 0) begin
            repeat (3) @(negedge clk);
            chk(!busy, "R11 start while busy ignored", int'(busy), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cnv == 1'b1, "R1 cnv after reset", int'(cnv), 1);
        chk(sclk == 1'b0, "R1 sclk after reset", int'(sclk), 0);
        chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
        chk(res_valid == 1'b0, "R1 valid after reset", int'(res_valid), 0);

        run_sample(2'b00, 12'hA5C, 12'h3C1, 4, 20, 2, 0, 0);   // transfer dominates
        run_sample(2'b00, 12'h5A3, 12'hF0F, 25, 8, 1, 0, 0);   // coincidence
        run_sample(2'b00, 12'h801, 12'h001, 40, 8, 1, 0, 0);   // timer dominates
        run_sample(2'b01, 12'h123, 12'hABC, 10, 50, 1, 1, 0);
        run_sample(2'b01, 12'hFFF, 12'h800, 3, 3, 2, 1, 0);
        run_sample(2'b10, 12'h6E9, 12'h7D2, 5, 30, 3, 2, 0);
        run_sample(2'b10, 12'h0F0, 12'h555, 13, 10, 1, 2, 0);  // coincidence
        run_sample(2'b11, 12'hC3A, 12'h2AA, 2, 6, 0, 0, 0);    // code 11 as 00, H=0 as 1
        run_sample(2'b01, 12'h9B4, 12'h4E1, 6, 12, 1, 1, 3);   // R11 late mode change

        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R9 all results delivered", exp_q.size(), 0);
        chk(r2_viol == 0, "R2 sclk idle while cnv high or not busy", r2_viol, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule